// File: doc/BRIEF.md
# External Bus Word Packer

This block sits between one internal requester and a narrow external memory bus. The requester issues a single read or write of a 16-bit or 24-bit word. The block breaks that access into as many external bus cycles as the configured data path needs, and walks the external address up by one for each cycle. It steers write bytes onto the correct lanes and gathers read bytes back into one word. The external data path can be set to 8 or 16 bits wide. The external address is 20 bits and the physical data bus is 16 bits.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request is accepted in the cycle where `req_valid` and `req_ready` are both high, and every request field is captured at that edge, including the bus width. The response also uses valid/ready. `rsp_valid` rises after the final bus cycle of the word completes. It holds, with stable `rsp_rdata`, until `rsp_ready` is high, which gives the requester back-pressure on the response. The block takes no new request until the response has been consumed.

On the external side, each bus cycle drives one strobe together with the address and any write data. That cycle stays unchanged until `ext_ack` is sampled high, so a slow device can stretch it for as many cycles as it needs.

Top module: `xbus_word_packer`

## Requirements
- R1: While reset is held and after it, `req_ready` is 1, `ext_rd`, `ext_wr` and `rsp_valid` are 0.
- R2: The number of bus cycles per access is 2 for a 16-bit word and 3 for a 24-bit word on the 8-bit path (`cfg_wide`=0), and 1 for a 16-bit word and 2 for a 24-bit word on the 16-bit path (`cfg_wide`=1); `req_size24`=1 selects the 24-bit word.
- R3: The first bus cycle uses the request address, and each later cycle uses the previous address plus one, wrapping modulo 2^20.
- R4: On the 8-bit path, write cycle k drives word bits [8k+7:8k] on `ext_dout[7:0]` and zero on `ext_dout[15:8]`.
- R5: On the 16-bit path, write cycle 0 drives word bits [15:0], and cycle 1 (24-bit word only) drives bits [23:16] on `ext_dout[7:0]` with zero on `ext_dout[15:8]`.
- R6: On the 8-bit path, read cycle k places `ext_din[7:0]` into response bits [8k+7:8k]; response bits not covered by the word are 0.
- R7: On the 16-bit path, read cycle 0 fills response bits [15:0] from `ext_din`, and cycle 1 fills bits [23:16] from `ext_din[7:0]`; `ext_din[15:8]` in cycle 1 is ignored.
- R8: A bus cycle keeps its address, strobe and write data unchanged until `ext_ack` is sampled high, and read data is taken only in that cycle.
- R9: During a bus cycle exactly one of `ext_rd` (read) or `ext_wr` (write) is high; outside bus cycles both are low.
- R10: `req_ready` is high only when no access or response is pending; `rsp_valid` rises in the cycle after the final bus cycle is acknowledged and holds with stable `rsp_rdata` until `rsp_ready`; a write response returns zero data.
- R11: Changes of `cfg_wide` and of the request inputs while an access is in progress have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | External data path width: 0 = 8 bits, 1 = 16 bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size24 | input | 1 | 1 = 24-bit word, 0 = 16-bit word |
| req_addr | input | 20 | Word start address |
| req_wdata | input | 24 | Write word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_rdata | output | 24 | Assembled read word |
| ext_addr | output | 20 | External address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_ack | input | 1 | Bus cycle completes when high |

## Verification
All eight combinations of direction, word size and path width are run. Some start near the top of the address space, so the address wrap is exercised, and 16-bit words carry nonzero upper bits that must never reach the bus. The acknowledge input is held high in some phases and pseudo-random in others. A random acknowledge pattern separates a design that waits for each cycle's acknowledge from one that advances or captures early. While a cycle waits, the read bus carries inverted garbage, so a capture outside the acknowledge cycle shows up in the response data. During every access the width select and the request inputs are scrambled, which separates fields captured at acceptance from fields read live. Random `rsp_ready` stalls show whether the response is held.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RESP = 2'd2
  } xbp_state_e;
endpackage

// File: rtl/xbp_sequencer.sv
module xbp_sequencer
  import xbp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BEAT_W-1:0] nbeats_in,
  input  logic              ext_ack,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              accept,
  output logic [BEAT_W-1:0] beat,
  output logic              beat_done,
  output logic              is_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic              rsp_valid
);
  xbp_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] last_q;
  logic              wr_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign beat      = beat_q;
  assign is_write  = wr_q;
  assign ext_addr  = base_q + ADDR_W'(beat_q);
  assign ext_rd    = (state_q == ST_BUS) && !wr_q;
  assign ext_wr    = (state_q == ST_BUS) && wr_q;
  assign beat_done = (state_q == ST_BUS) && ext_ack;
  assign rsp_valid = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          base_q  <= req_addr;
          wr_q    <= req_write;
          beat_q  <= '0;
          last_q  <= nbeats_in - BEAT_W'(1);
          state_q <= ST_BUS;
        end
        ST_BUS: if (ext_ack) begin
          if (beat_q == last_q) state_q <= ST_RESP;
          else                  beat_q  <= beat_q + BEAT_W'(1);
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbp_wlane.sv
module xbp_wlane #(
  parameter int WORD_W = 24,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic [WORD_W-1:0] wdata,
  input  logic              wide,
  input  logic [BEAT_W-1:0] beat,
  output logic [BUS_W-1:0]  dout
);
  localparam int EXT_W = WORD_W + BUS_W;
  localparam int SH_W  = $clog2(EXT_W + 1) + BEAT_W;

  logic [SH_W-1:0]  sh;
  logic [EXT_W-1:0] ext;

  always_comb begin
    sh   = wide ? SH_W'(beat) * SH_W'(BUS_W) : SH_W'(beat) * SH_W'(LANE_W);
    ext  = {{BUS_W{1'b0}}, wdata} >> sh;
    dout = wide ? ext[BUS_W-1:0] : {{(BUS_W-LANE_W){1'b0}}, ext[LANE_W-1:0]};
  end
endmodule

// File: rtl/xbp_rassemble.sv
module xbp_rassemble #(
  parameter int WORD_W = 24,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BUS_W-1:0]  din,
  output logic [WORD_W-1:0] rdata
);
  localparam int EXT_W = WORD_W + BUS_W;
  localparam int SH_W  = $clog2(EXT_W + 1) + BEAT_W;

  logic [SH_W-1:0]  sh;
  logic [BUS_W-1:0] lane;
  logic [EXT_W-1:0] placed;

  always_comb begin
    sh     = wide ? SH_W'(beat) * SH_W'(BUS_W) : SH_W'(beat) * SH_W'(LANE_W);
    lane   = wide ? din : {{(BUS_W-LANE_W){1'b0}}, din[LANE_W-1:0]};
    placed = {{WORD_W{1'b0}}, lane} << sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) rdata <= '0;
    else if (capture)    rdata <= rdata | placed[WORD_W-1:0];
  end
endmodule

// File: rtl/xbus_word_packer.sv
module xbus_word_packer #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8,
  parameter int WORD_S = 16,
  parameter int WORD_L = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_size24,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_L-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_L-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BUS_W-1:0]  ext_dout,
  input  logic [BUS_W-1:0]  ext_din,
  output logic              ext_rd,
  output logic              ext_wr,
  input  logic              ext_ack
);
  localparam int NB_NS  = (WORD_S + LANE_W - 1) / LANE_W;
  localparam int NB_NL  = (WORD_L + LANE_W - 1) / LANE_W;
  localparam int NB_WS  = (WORD_S + BUS_W - 1) / BUS_W;
  localparam int NB_WL  = (WORD_L + BUS_W - 1) / BUS_W;
  localparam int BEAT_W = $clog2(NB_NL + 1);

  logic              accept, beat_done, is_write;
  logic [BEAT_W-1:0] beat, nbeats;
  logic [WORD_L-1:0] wdata_q, wdata_masked;
  logic              wide_q;

  always_comb begin
    if (cfg_wide) nbeats = req_size24 ? BEAT_W'(NB_WL) : BEAT_W'(NB_WS);
    else          nbeats = req_size24 ? BEAT_W'(NB_NL) : BEAT_W'(NB_NS);
    wdata_masked = req_size24 ? req_wdata : WORD_L'(req_wdata[WORD_S-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wide_q  <= 1'b0;
    end else if (accept) begin
      wdata_q <= wdata_masked;
      wide_q  <= cfg_wide;
    end
  end

  xbp_sequencer #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .nbeats_in(nbeats), .ext_ack(ext_ack),
    .rsp_ready(rsp_ready), .req_ready(req_ready), .accept(accept),
    .beat(beat), .beat_done(beat_done), .is_write(is_write),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .rsp_valid(rsp_valid)
  );

  xbp_wlane #(.WORD_W(WORD_L), .BUS_W(BUS_W), .LANE_W(LANE_W), .BEAT_W(BEAT_W)) u_wl (
    .wdata(wdata_q), .wide(wide_q), .beat(beat), .dout(ext_dout)
  );

  xbp_rassemble #(.WORD_W(WORD_L), .BUS_W(BUS_W), .LANE_W(LANE_W), .BEAT_W(BEAT_W)) u_ra (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .capture(beat_done && !is_write), .wide(wide_q), .beat(beat),
    .din(ext_din), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/xbp_checker.sv
module xbp_checker #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16,
  parameter int WORD_L = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wide,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_size24,
  input logic [ADDR_W-1:0] req_addr,
  input logic [WORD_L-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_L-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [BUS_W-1:0]  ext_dout,
  input logic [BUS_W-1:0]  ext_din,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic              ext_ack
);
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  assert_cycle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && !ext_ack) |=>
      ($stable(ext_addr) && $stable(ext_rd) && $stable(ext_wr) && $stable(ext_dout)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && ext_ack) |=>
      (!(ext_rd || ext_wr) || ext_addr == $past(ext_addr) + ADDR_W'(1)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ext_rd && !ext_wr && !rsp_valid));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_rsp_after_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(ext_ack && (ext_rd || ext_wr)));
endmodule

bind xbus_word_packer xbp_checker u_chk (.*);

// File: tb/xbus_word_packer_test.sv
module xbus_word_packer_test;
  localparam int NTX = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_size24 = 1'b0;
  logic [19:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        rsp_ready = 1'b0, ext_ack = 1'b0;
  logic        req_ready, rsp_valid, ext_rd, ext_wr;
  logic [23:0] rsp_rdata;
  logic [19:0] ext_addr;
  logic [15:0] ext_dout, ext_din;

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(input logic [19:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0] + 8'h17};
  endfunction

  assign ext_din = ext_ack ? memf(ext_addr) : ~memf(ext_addr);

  xbus_word_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size24(req_size24),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_din(ext_din), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_ack(ext_ack)
  );

  int checks = 0, fails = 0, cycles = 0, ti = 0, mst = 0;
  int obs_beats = 0, exp_beats = 0;
  bit running = 0, first_resp = 0, m_write = 0, m_wide = 0, m_hold = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [19:0] qa[$];
  logic [15:0] qd[$];
  logic [19:0] prev_addr = '0;
  logic [23:0] m_rexp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic build(input bit wr, input bit l24, input bit wd, input logic [19:0] a, input logic [23:0] w);
    logic [23:0] wm;
    int n;
    wm = l24 ? w : {8'h00, w[15:0]};
    n  = wd ? (l24 ? 2 : 1) : (l24 ? 3 : 2);
    qa.delete(); qd.delete();
    m_rexp = '0;
    for (int k = 0; k < n; k++) begin
      logic [19:0] ak;
      ak = a + 20'(k);
      qa.push_back(ak);
      if (wd) begin
        qd.push_back(k == 0 ? wm[15:0] : {8'h00, wm[23:16]});
        if (!wr) begin
          if (k == 0) m_rexp[15:0] = memf(ak);
          else        m_rexp[23:16] = memf(ak)[7:0];
        end
      end else begin
        qd.push_back({8'h00, wm[8*k +: 8]});
        if (!wr) m_rexp[8*k +: 8] = memf(ak)[7:0];
      end
    end
    exp_beats = n;
    m_write = wr; m_wide = wd;
  endtask

  always @(negedge clk) begin
    if (running) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // Output checks against the model state
      chk(req_ready == (mst == 0), "R10 req_ready", 32'(req_ready), 32'(mst == 0));
      chk(rsp_valid == (mst == 2), "R10 rsp_valid", 32'(rsp_valid), 32'(mst == 2));
      if (mst == 1) begin
        chk(ext_wr == m_write && ext_rd == !m_write, "R9 strobe",
            {30'd0, ext_rd, ext_wr}, {30'd0, !m_write, m_write});
        chk(ext_addr == qa[0], m_hold ? "R8 held addr" : "R3 addr", 32'(ext_addr), 32'(qa[0]));
        if (m_write)
          chk(ext_dout == qd[0], m_wide ? "R5 wdata" : "R4 wdata", 32'(ext_dout), 32'(qd[0]));
      end else begin
        chk(!ext_rd && !ext_wr, "R9 idle strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
      end
      if (mst == 2) begin
        if (first_resp)
          chk(obs_beats == exp_beats, "R2 beat count", 32'(obs_beats), 32'(exp_beats));
        chk(rsp_rdata == m_rexp,
            m_write ? "R10 write rsp" : (m_wide ? "R7/R11 rdata" : "R6/R11 rdata"),
            32'(rsp_rdata), 32'(m_rexp));
      end
      first_resp = 0;

      if (mst == 0 && ti == NTX) finish_run();

      // Drive inputs
      ext_ack   = (ti < 8) ? 1'b1 : lfsr[0];
      rsp_ready = lfsr[3] | lfsr[5];
      if (mst == 0) begin
        bit wr, l24, wd;
        wr  = ti[0]; l24 = ti[1]; wd = ti[2];
        req_valid  = 1'b1;
        req_write  = wr;
        req_size24 = l24;
        cfg_wide   = wd;
        req_addr   = (ti % 4 == 3) ? 20'hFFFFF - 20'(ti % 3) : 20'h01230 + 20'(ti * 37);
        req_wdata  = 24'hA5C3E7 ^ (24'(ti) * 24'h010203);
      end else begin
        // R11: scramble inputs while busy
        req_valid  = lfsr[1];
        req_write  = lfsr[2];
        req_size24 = lfsr[4];
        cfg_wide   = lfsr[6];
        req_addr   = {lfsr[3:0], lfsr};
        req_wdata  = {lfsr[7:0], ~lfsr};
      end
      if ((ext_rd || ext_wr) && ext_ack) obs_beats++;

      // Model update for the coming edge
      if (mst == 1) begin
        prev_addr = qa[0];
        if (ext_ack) begin
          void'(qa.pop_front()); void'(qd.pop_front());
          m_hold = 0;
          if (qa.size() == 0) begin mst = 2; first_resp = 1; end
        end else m_hold = 1;
      end else if (mst == 2) begin
        if (rsp_ready) mst = 0;
      end else if (req_valid) begin
        build(req_write, req_size24, cfg_wide, req_addr, req_wdata);
        obs_beats = 0;
        m_hold = 0;
        ti++;
        mst = 1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
    chk(!ext_rd && !ext_wr, "R1 reset strobes", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid, "R1 after reset", {30'd0, req_ready, rsp_valid}, 32'd2);
    running = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      finish_run();
    end
  end
endmodule